// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a slower block-organised memory. A word address is split into a tag, a set index and a word offset. The tags of every way in the selected set are checked at the same time. A read hit returns a stored word. A write hit changes only the cached copy and marks the line as modified. A miss picks a victim way in the set. If that victim holds modified data, the whole victim block is first written out to memory. The missing block is then read in, and the original access is replayed against the freshly filled line.

The processor side uses a simple start/complete handshake: a request is taken while the cache is idle, and completion is signalled by a one-cycle `cpu_ready` pulse. The memory side moves one full block per transaction. A transaction is held steady until memory acknowledges it. Replacement is least-recently-used within each set, and empty ways are always used before any valid way is evicted.

Top module: `sa_wb_cache`

## Requirements
- R1: The word address is decoded as {tag, set index, word offset}, with the offset in the lowest log2(WORDS) bits and the index in the next log2(SETS) bits. The set is therefore the block address modulo SETS, and blocks that map to different sets never evict each other.
- R2: A read hit returns the stored word on `cpu_rdata` with `cpu_ready` and `cpu_hit` high, one cycle after the cycle in which the request was taken. At most one way matches at any time.
- R3: A write hit updates only the cached word and marks the line modified. No memory transaction is issued.
- R4: When the chosen victim is valid and modified, a block write of the victim (address = victim tag and set index, data = its current contents) is issued and acknowledged before the block read for the missing block.
- R5: A write miss first reads the whole block from memory, then merges the written word into it. The other words of that block keep their memory values.
- R6: The victim is the first invalid way (lowest way number). When all ways are valid, it is the least recently used way of the set. A hit or fill makes its way the most recently used.
- R7: With SETS=2 and WAYS=2, reads of block addresses 0, 8, 0, 6, 8 after reset give miss, miss, hit, miss, miss.
- R8: A miss whose victim is invalid or unmodified issues only a block read, with no block write.
- R9: After reset all lines are invalid, `cpu_ready` and `mem_req` are low, and the first access to any block misses.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R11: `cpu_ready` is a single-cycle pulse. `cpu_hit` is high with it exactly when the access needed no memory transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken while the cache is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access completed without memory traffic |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| mem_req | output | 1 | Block transaction request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W-log2(WORDS) | Block address |
| mem_wdata | output | DATA_W*WORDS | Block being written back |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W*WORDS | Block read data, valid with mem_ack |

## Verification
A fixed associativity sequence checks the exact hit/miss pattern. It is the one that tells LRU replacement apart from index-only placement. Directed writes then separate a clean eviction (read only) from a dirty one (write-back first, carrying the latest written word), and a write miss is checked for merging into the fetched block. Constrained-random traffic over four tags per set mixes reads and writes. It exercises conflict and capacity evictions, and compares every hit flag, returned word, write-back address and write-back block against a timestamp-based reference model and a golden word memory.

// File: rtl/sawb_pkg.sv
package sawb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRBACK,
        ST_FETCH
    } ctl_state_e;

    // Position of the lowest set bit; 0 when none is set.
    function automatic int unsigned lowest_one(input logic [31:0] vec);
        int unsigned pos;
        pos = 0;
        for (int i = 31; i >= 0; i--) begin
            if (vec[i]) pos = unsigned'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/sawb_tag_store.sv
module sawb_tag_store #(
    parameter int SETS  = 2,
    parameter int WAYS  = 2,
    parameter int TAG_W = 10
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [$clog2(SETS)-1:0]         idx,
    input  logic [TAG_W-1:0]                cmp_tag,
    output logic [WAYS-1:0]                 hit_vec,
    output logic [WAYS-1:0]                 valid_vec,
    output logic [WAYS-1:0]                 dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]      tag_vec,
    input  logic                            fill_en,
    input  logic [$clog2(WAYS)-1:0]         fill_way,
    input  logic [TAG_W-1:0]                fill_tag,
    input  logic                            dirty_en,
    input  logic [$clog2(WAYS)-1:0]         dirty_way
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  vld_q   [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]   <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (fill_en) begin
                tag_q[idx][fill_way]   <= fill_tag;
                vld_q[idx][fill_way]   <= 1'b1;
                dirty_q[idx][fill_way] <= 1'b0;
            end
            if (dirty_en) begin
                dirty_q[idx][dirty_way] <= 1'b1;
            end
        end
    end

    // One comparator per way, all evaluated together.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_vec[w]   = tag_q[idx][w];
        assign valid_vec[w] = vld_q[idx][w];
        assign dirty_vec[w] = dirty_q[idx][w];
        assign hit_vec[w]   = vld_q[idx][w] && (tag_q[idx][w] == cmp_tag);
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2
    AST_DIRTY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        dirty_en |-> valid_vec[dirty_way]); // R3

endmodule

// File: rtl/sawb_data_store.sv
module sawb_data_store #(
    parameter int SETS   = 2,
    parameter int WAYS   = 2,
    parameter int WORDS  = 2,
    parameter int DATA_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [$clog2(SETS)-1:0]               idx,
    output logic [WAYS-1:0][DATA_W*WORDS-1:0]     blk_rd,
    input  logic                                  blk_we,
    input  logic [$clog2(WAYS)-1:0]               blk_way,
    input  logic [DATA_W*WORDS-1:0]               blk_wdata,
    input  logic                                  word_we,
    input  logic [$clog2(WAYS)-1:0]               word_way,
    input  logic [$clog2(WORDS)-1:0]              word_sel,
    input  logic [DATA_W-1:0]                     word_wdata
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int BLK_W = DATA_W * WORDS;

    logic [BLK_W-1:0] line_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (blk_we) begin
            line_q[idx][blk_way] <= blk_wdata;
        end
        for (int k = 0; k < WORDS; k++) begin
            if (word_we && word_sel == OFF_W'(k)) begin
                line_q[idx][word_way][k*DATA_W +: DATA_W] <= word_wdata;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign blk_rd[w] = line_q[idx][w];
    end

    AST_FILL_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
        !(blk_we && word_we)); // R5

endmodule

// File: rtl/sawb_repl.sv
module sawb_repl #(
    parameter int SETS = 2,
    parameter int WAYS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(SETS)-1:0]      idx,
    input  logic [WAYS-1:0]              valid_vec,
    input  logic                         acc_en,
    input  logic [$clog2(WAYS)-1:0]      acc_way,
    output logic [$clog2(WAYS)-1:0]      victim
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;

    // Each way keeps its recency rank: 0 = newest, WAYS-1 = oldest.
    logic [AGE_W-1:0] age_q [SETS][WAYS];
    logic             found;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (acc_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == acc_way) begin
                    age_q[idx][w] <= '0;
                end else if (age_q[idx][w] < age_q[idx][acc_way]) begin
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_vec[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[idx][w] == AGE_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end

    AST_VICTIM_NOT_MRU: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> (idx != $past(idx)) || !(&valid_vec) || (victim != $past(acc_way))); // R6

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WORDS  = 2,
    parameter int SETS   = 2,
    parameter int WAYS   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cpu_req,
    input  logic                                   cpu_we,
    input  logic [ADDR_W-1:0]                      cpu_addr,
    input  logic [DATA_W-1:0]                      cpu_wdata,
    output logic                                   cpu_ready,
    output logic                                   cpu_hit,
    output logic [DATA_W-1:0]                      cpu_rdata,
    output logic                                   mem_req,
    output logic                                   mem_we,
    output logic [ADDR_W-$clog2(WORDS)-1:0]        mem_addr,
    output logic [DATA_W*WORDS-1:0]                mem_wdata,
    input  logic                                   mem_ack,
    input  logic [DATA_W*WORDS-1:0]                mem_rdata
);
    import sawb_pkg::*;

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W = DATA_W * WORDS;

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              missed_q;
    logic [WAY_W-1:0]  victim_q;
    logic              ready_q;
    logic              hit_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;

    logic [WAYS-1:0]              hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0]   tag_vec;
    logic [WAYS-1:0][BLK_W-1:0]   blk_rd;
    logic                         hit_any;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic [DATA_W-1:0]            hit_word;
    logic                         do_hit;
    logic                         do_fill;

    assign req_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign req_idx = addr_q[OFF_W +: IDX_W];
    assign req_off = addr_q[OFF_W-1:0];

    assign hit_any = |hit_vec;
    assign hit_way = WAY_W'(lowest_one(32'(hit_vec)));
    assign do_hit  = (state_q == ST_COMPARE) && hit_any;
    assign do_fill = (state_q == ST_FETCH) && mem_ack;

    always_comb begin
        hit_word = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (req_off == OFF_W'(k)) hit_word = blk_rd[hit_way][k*DATA_W +: DATA_W];
        end
    end

    sawb_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .idx       (req_idx),
        .cmp_tag   (req_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .tag_vec   (tag_vec),
        .fill_en   (do_fill),
        .fill_way  (victim_q),
        .fill_tag  (req_tag),
        .dirty_en  (do_hit && we_q),
        .dirty_way (hit_way)
    );

    sawb_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .idx        (req_idx),
        .blk_rd     (blk_rd),
        .blk_we     (do_fill),
        .blk_way    (victim_q),
        .blk_wdata  (mem_rdata),
        .word_we    (do_hit && we_q),
        .word_way   (hit_way),
        .word_sel   (req_off),
        .word_wdata (wdata_q)
    );

    sawb_repl #(.SETS(SETS), .WAYS(WAYS)) u_repl (
        .clk       (clk),
        .rst       (rst),
        .idx       (req_idx),
        .valid_vec (valid_vec),
        .acc_en    (do_hit),
        .acc_way   (hit_way),
        .victim    (victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            missed_q <= 1'b0;
            victim_q <= '0;
            ready_q  <= 1'b0;
            hit_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ready_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        addr_q   <= cpu_addr;
                        we_q     <= cpu_we;
                        wdata_q  <= cpu_wdata;
                        missed_q <= 1'b0;
                        state_q  <= ST_COMPARE;
                    end
                end
                ST_COMPARE: begin
                    if (hit_any) begin
                        ready_q <= 1'b1;
                        hit_q   <= !missed_q;
                        rdata_q <= we_q ? wdata_q : hit_word;
                        state_q <= ST_IDLE;
                    end else begin
                        missed_q <= 1'b1;
                        victim_q <= victim;
                        state_q  <= (valid_vec[victim] && dirty_vec[victim]) ? ST_WRBACK : ST_FETCH;
                    end
                end
                ST_WRBACK: begin
                    if (mem_ack) state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_ack) state_q <= ST_COMPARE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = ready_q;
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;

    assign mem_req   = (state_q == ST_WRBACK) || (state_q == ST_FETCH);
    assign mem_we    = (state_q == ST_WRBACK);
    assign mem_addr  = (state_q == ST_WRBACK) ? {tag_vec[victim_q], req_idx} : {req_tag, req_idx};
    assign mem_wdata = blk_rd[victim_q];

    AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R4
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R10
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready); // R11
    AST_REFILL_HITS: assert property (@(posedge clk) disable iff (rst)
        do_fill |=> hit_any); // R5

endmodule

// File: tb/sa_wb_cache_tb.sv
module sa_wb_cache_tb_top;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WORDS   = 2;
    localparam int SETS    = 2;
    localparam int WAYS    = 2;
    localparam int OFF_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(SETS);
    localparam int BADDR_W = ADDR_W - OFF_W;
    localparam int BLK_W   = DATA_W * WORDS;
    localparam int NBLK    = 1 << BADDR_W;
    localparam int NWORD   = 1 << ADDR_W;
    localparam int MEM_LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_hit;
    logic [DATA_W-1:0] cpu_rdata;
    logic mem_req, mem_we;
    logic [BADDR_W-1:0] mem_addr;
    logic [BLK_W-1:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [BLK_W-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sa_wb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [BLK_W-1:0]  bmem [NBLK];
    logic [DATA_W-1:0] gmem [NWORD];

    bit m_vld   [SETS][WAYS];
    bit m_dirty [SETS][WAYS];
    int m_tag   [SETS][WAYS];
    int m_stamp [SETS][WAYS];
    int now_t = 0;

    int wb_cnt, rd_cnt, wb_addr, rd_addr;
    bit order_bad;
    logic [BLK_W-1:0] wb_data;

    function automatic logic [DATA_W-1:0] seed_word(input int a);
        return DATA_W'(32'hA500_0000 ^ (a * 32'h0000_9E37));
    endfunction

    function automatic int find_way(input int s, input int t);
        for (int w = 0; w < WAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int pick_victim(input int s);
        int v;
        for (int w = 0; w < WAYS; w++) if (!m_vld[s][w]) return w;
        v = 0;
        for (int w = 1; w < WAYS; w++) if (m_stamp[s][w] < m_stamp[s][v]) v = w;
        return v;
    endfunction

    function automatic logic [BLK_W-1:0] golden_blk(input int b);
        logic [BLK_W-1:0] r;
        for (int k = 0; k < WORDS; k++) r[k*DATA_W +: DATA_W] = gmem[b*WORDS + k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: acknowledges each block transaction after MEM_LAT cycles.
    initial begin
        int wait_c;
        wait_c = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_c = 0;
            end else if (mem_req) begin
                if (wait_c == MEM_LAT) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        bmem[mem_addr] = mem_wdata;
                        wb_cnt++;
                        wb_addr = int'(mem_addr);
                        wb_data = mem_wdata;
                        if (rd_cnt > 0) order_bad = 1'b1;
                    end else begin
                        mem_rdata = bmem[mem_addr];
                        rd_cnt++;
                        rd_addr = int'(mem_addr);
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic access(input bit we, input int a, input logic [DATA_W-1:0] d,
                          input string req, output bit got_hit, output int got_wb);
        int s, t, b, w, v, cyc;
        bit exp_hit, exp_wb;
        int exp_wb_addr;
        logic [BLK_W-1:0] exp_wb_data;
        b = a >> OFF_W;
        s = b % SETS;
        t = b >> IDX_W;
        w = find_way(s, t);
        exp_hit = (w >= 0);
        v = exp_hit ? w : pick_victim(s);
        exp_wb = !exp_hit && m_vld[s][v] && m_dirty[s][v];
        exp_wb_addr = m_tag[s][v] * SETS + s;
        exp_wb_data = golden_blk(exp_wb_addr);
        wb_cnt = 0; rd_cnt = 0; order_bad = 1'b0;

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 0;
        while (!cpu_ready && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        got_hit = cpu_hit;
        got_wb = wb_cnt;
        chk(cpu_ready, req, "completion seen", 128'(cpu_ready), 1);
        chk(cpu_hit == exp_hit, {req, "/R6/R11"}, "hit flag", 128'(cpu_hit), 128'(exp_hit));
        if (!we) chk(cpu_rdata == gmem[a], {req, "/R2"}, "read data", cpu_rdata, gmem[a]);
        if (exp_hit) chk(cyc == 1, "R2", "hit latency", cyc, 1);
        chk(wb_cnt == int'(exp_wb), {req, "/R4/R8"}, "write-back count", wb_cnt, exp_wb);
        chk(rd_cnt == int'(!exp_hit), {req, "/R3"}, "fetch count", rd_cnt, !exp_hit);
        chk(!order_bad, "R4", "write-back before fetch", order_bad, 0);
        if (exp_wb) begin
            chk(wb_addr == exp_wb_addr, "R4", "write-back address", wb_addr, exp_wb_addr);
            chk(wb_data == exp_wb_data, "R4", "write-back block", wb_data, exp_wb_data);
        end
        if (!exp_hit) chk(rd_addr == b, "R1", "fetch address", rd_addr, b);
        @(negedge clk);
        chk(!cpu_ready, "R11", "ready is one pulse", cpu_ready, 0);

        if (!exp_hit) begin
            m_vld[s][v] = 1'b1; m_dirty[s][v] = 1'b0; m_tag[s][v] = t;
        end
        now_t++;
        m_stamp[s][v] = now_t;
        if (we) begin
            m_dirty[s][v] = 1'b1;
            gmem[a] = d;
        end
    endtask

    initial begin
        bit h;
        int nwb;
        bit exp_seq [5];
        int seq [5];
        void'($urandom(32'd20240611));
        for (int i = 0; i < NWORD; i++) gmem[i] = seed_word(i);
        for (int b = 0; b < NBLK; b++) bmem[b] = golden_blk(b);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
            end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, "R9", "ready low after reset", cpu_ready, 0);
        chk(!mem_req, "R9", "mem_req low after reset", mem_req, 0);

        // R7 associativity sequence on block addresses
        seq = '{0, 8, 0, 6, 8};
        exp_seq = '{0, 0, 1, 0, 0};
        for (int i = 0; i < 5; i++) begin
            access(1'b0, seq[i] * WORDS, '0, "R7", h, nwb);
            chk(h == exp_seq[i], "R7", "sequence hit/miss", h, exp_seq[i]);
        end

        // R1: block 1 lives in the other set and leaves set 0 intact
        access(1'b0, 1 * WORDS, '0, "R1", h, nwb);
        chk(!h, "R1", "other set miss", h, 0);
        access(1'b0, 8 * WORDS, '0, "R1", h, nwb);
        chk(h, "R1", "set 0 untouched", h, 1);

        // R3: write hit, memory untouched
        access(1'b1, 8 * WORDS + 1, 32'hDEAD_BEEF, "R3", h, nwb);
        chk(h && nwb == 0, "R3", "write hit no traffic", {h, 8'(nwb)}, 9'h100);
        chk(bmem[8][DATA_W +: DATA_W] == seed_word(8 * WORDS + 1), "R3", "memory not updated",
            bmem[8][DATA_W +: DATA_W], seed_word(8 * WORDS + 1));
        access(1'b0, 8 * WORDS + 1, '0, "R3", h, nwb);

        // R8: block 10 evicts clean block 6
        access(1'b0, 10 * WORDS, '0, "R8", h, nwb);
        chk(nwb == 0, "R8", "clean eviction no write-back", nwb, 0);
        access(1'b0, 10 * WORDS, '0, "R6", h, nwb);
        // R4: block 12 evicts dirty block 8
        access(1'b0, 12 * WORDS, '0, "R4", h, nwb);
        chk(nwb == 1, "R4", "dirty eviction write-back", nwb, 1);
        chk(bmem[8][DATA_W +: DATA_W] == 32'hDEAD_BEEF, "R4", "written word reached memory",
            bmem[8][DATA_W +: DATA_W], 32'hDEAD_BEEF);

        // R5: write miss allocates and merges
        access(1'b1, 20 * WORDS, 32'h1234_5678, "R5", h, nwb);
        chk(!h, "R5", "write miss", h, 0);
        access(1'b0, 20 * WORDS + 1, '0, "R5", h, nwb);
        chk(h && cpu_rdata == seed_word(20 * WORDS + 1), "R5", "untouched word from memory",
            cpu_rdata, seed_word(20 * WORDS + 1));
        access(1'b0, 20 * WORDS, '0, "R5", h, nwb);
        chk(cpu_rdata == 32'h1234_5678, "R5", "merged word", cpu_rdata, 32'h1234_5678);

        // Constrained random traffic: four tags per set
        for (int i = 0; i < 400; i++) begin
            int t, s, o;
            t = int'($urandom_range(3, 0));
            s = int'($urandom_range(SETS - 1, 0));
            o = int'($urandom_range(WORDS - 1, 0));
            access(($urandom_range(1, 0) == 1), ((t * SETS + s) * WORDS) + o,
                   $urandom, "R6", h, nwb);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule